// File: doc/BRIEF.md
# Ping-Pong Output Tile Buffer Controller

This controller sequences a tiled convolution so that three engines overlap. A compute engine accumulates the current tile into one of two output buffers. A store engine writes the other buffer, which holds the previous tile's results, out to external memory. A load engine fetches the inputs for the following tile. One flag register decides which buffer each side owns. The flag flips at every tile boundary, so compute and store always work on opposite buffers.

A run begins with a `go` pulse carrying the tile count N. The first step is a prologue phase that only loads tile 0. The run then steps through phases 0..N:
- Phase p computes tile p when p < N.
- Phase p stores tile p-1 when p >= 1.
- Phase p loads tile p+1 when p+1 < N.

Phase 0 therefore issues no store, because the idle buffer holds nothing yet. Phase N is a drain phase that only stores. A phase ends once every engine started in it has returned done. The next phase's start pulses then appear in the following cycle, and the flag changes on that same edge.

Every compute start tells the engine that its first accumulation into the selected buffer overwrites the old contents instead of adding to them. This is how each newly selected buffer is cleared.

Top module: `pingpong_tile_ctrl`

## Requirements
- R1: During and after reset, `busy` is 0 and `cmp_start`, `st_start` and `ld_start` are all 0. While `busy` is 0, no start pulse is issued.
- R2: A `go` sampled while idle with a nonzero `num_tiles` raises `busy` and produces a prologue. In the prologue, only `ld_start` pulses, in the cycle after the sampling edge, and `phase` reads 0.
- R3: During phase p, `phase` equals p and `cmp_buf` equals bit 0 of p (0 selects buffer one, 1 selects buffer two). `st_buf` is always the inverse of `cmp_buf`. The flag changes only when `phase` changes.
- R4: In phase 0, `cmp_start` pulses and `st_start` does not.
- R5: `ld_start` pulses together with `cmp_start` in phase p exactly when p+1 < N.
- R6: In phase N (the drain phase), only `st_start` pulses. No compute or load is started.
- R7: A phase advances only after every engine started in it has signalled done. Dones may arrive in any order, and may arrive in the start cycle itself. The next phase's starts appear in the cycle after the last of those dones.
- R8: Each start is a pulse of exactly one cycle, issued once per phase per engine.
- R9: These inputs are ignored: a `go` while `busy`, a `go` with `num_tiles` equal to 0, and a done from an engine that has nothing outstanding.
- R10: `busy` returns to 0 in the cycle after the last done of the drain phase, and no further starts follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Begin a run of `num_tiles` tiles |
| num_tiles | input | TW | Tile count N, sampled with `go` |
| ld_start | output | 1 | Pulse: load next tile's weights and features |
| ld_done | input | 1 | Load engine finished |
| cmp_start | output | 1 | Pulse: compute a tile, first accumulation overwrites |
| cmp_done | input | 1 | Compute engine finished |
| cmp_buf | output | 1 | Buffer targeted by compute (the flag) |
| st_start | output | 1 | Pulse: write the idle buffer to memory |
| st_done | input | 1 | Store engine finished |
| st_buf | output | 1 | Buffer drained by store |
| busy | output | 1 | A run is in progress |
| phase | output | TW | Current phase index |

## Verification
The completion of one phase and the start of the next can coincide. This happens when an engine returns done in the very cycle its start pulse is visible: the controller must then launch the next phase on the following edge, with no bubble and no lost acknowledgement. The bench draws engine latencies of zero as well as longer ones and injects stray dones from idle engines. It tracks from its own phase arithmetic which starts must appear in the cycle after the last outstanding done. A `go` arriving in the final drain cycle, when `busy` is about to fall, is also provoked. It is judged by requiring `busy` low and no starts afterwards.

// File: rtl/pingpong_tile_ctrl.sv
module pingpong_tile_ctrl #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [TW-1:0] num_tiles,
  output logic          ld_start,
  input  logic          ld_done,
  output logic          cmp_start,
  input  logic          cmp_done,
  output logic          cmp_buf,
  output logic          st_start,
  input  logic          st_done,
  output logic          st_buf,
  output logic          busy,
  output logic [TW-1:0] phase
);
  typedef enum logic [1:0] {S_IDLE, S_PRE, S_RUN} state_t;

  state_t        st_q;
  logic [TW-1:0] ntl_q, ph_q;
  logic          flag_q;
  logic [2:0]    pend_q;
  logic          cs_q, ss_q, ls_q;

  wire [2:0]  dn      = {ld_done, st_done, cmp_done};
  wire        clear   = ~|(pend_q & ~dn);
  wire        in_run  = (st_q == S_RUN);
  wire        last    = in_run && (ph_q == ntl_q);
  wire [TW:0] np      = in_run ? ({1'b0, ph_q} + 1'b1) : '0;
  wire        c_n     = np < {1'b0, ntl_q};
  wire        s_n     = np != '0;
  wire        l_n     = (np + 1'b1) < {1'b0, ntl_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ntl_q  <= '0;
      ph_q   <= '0;
      flag_q <= 1'b0;
      pend_q <= '0;
      cs_q   <= 1'b0;
      ss_q   <= 1'b0;
      ls_q   <= 1'b0;
    end else begin
      cs_q <= 1'b0;
      ss_q <= 1'b0;
      ls_q <= 1'b0;
      if (st_q == S_IDLE) begin
        if (go && |num_tiles) begin
          st_q   <= S_PRE;
          ntl_q  <= num_tiles;
          ph_q   <= '0;
          flag_q <= 1'b0;
          ls_q   <= 1'b1;
          pend_q <= 3'b100;
        end
      end else if (clear) begin
        if (last) begin
          st_q   <= S_IDLE;
          pend_q <= '0;
        end else begin
          st_q   <= S_RUN;
          ph_q   <= np[TW-1:0];
          flag_q <= flag_q ^ in_run;
          cs_q   <= c_n;
          ss_q   <= s_n;
          ls_q   <= l_n;
          pend_q <= {l_n, s_n, c_n};
        end
      end else begin
        pend_q <= pend_q & ~dn;
      end
    end
  end

  assign cmp_start = cs_q;
  assign st_start  = ss_q;
  assign ld_start  = ls_q;
  assign cmp_buf   = flag_q;
  assign st_buf    = ~flag_q;
  assign busy      = (st_q != S_IDLE);
  assign phase     = ph_q;
endmodule

// File: rtl/pingpong_tile_ctrl_chk.sv
module pingpong_tile_ctrl_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmp_start,
  input logic          st_start,
  input logic          ld_start,
  input logic          cmp_buf,
  input logic          busy,
  input logic [TW-1:0] phase
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(cmp_start || st_start || ld_start));

  p_flag_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && phase != $past(phase)) |-> (cmp_buf != $past(cmp_buf)));

  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && phase == $past(phase)) |-> $stable(cmp_buf));

  p_first_no_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_start && phase == '0) |-> !st_start);

  p_load_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_start && !cmp_start) |-> (phase == '0 && !st_start));
endmodule

bind pingpong_tile_ctrl pingpong_tile_ctrl_chk #(.TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmp_start(cmp_start), .st_start(st_start),
  .ld_start(ld_start), .cmp_buf(cmp_buf), .busy(busy), .phase(phase)
);

// File: tb/pingpong_tile_ctrl_tb_top.sv
`timescale 1ns/1ps
module pingpong_tile_ctrl_tb_top;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [TW-1:0] num_tiles = '0;
  logic ld_done = 1'b0, cmp_done = 1'b0, st_done = 1'b0;
  logic ld_start, cmp_start, st_start, cmp_buf, st_buf, busy;
  logic [TW-1:0] phase;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pingpong_tile_ctrl #(.TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .num_tiles(num_tiles),
    .ld_start(ld_start), .ld_done(ld_done),
    .cmp_start(cmp_start), .cmp_done(cmp_done), .cmp_buf(cmp_buf),
    .st_start(st_start), .st_done(st_done), .st_buf(st_buf),
    .busy(busy), .phase(phase)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_cmp(input int p, input int n);
    return (p >= 0) && (p < n);
  endfunction
  function automatic bit exp_st(input int p);
    return p >= 1;
  endfunction
  function automatic bit exp_ld(input int p, input int n);
    return (p + 1) < n;
  endfunction

  task automatic run_tiles(input int n, input int maxlat, input bit noise);
    int  p = -2;
    bit  adv = 1'b1;
    bit  act [3];
    int  rem [3];
    bit  d [3];
    int  cyc = 0;
    for (int i = 0; i < 3; i++) begin act[i] = 1'b0; rem[i] = 0; end
    @(negedge clk);
    go = 1'b1;
    num_tiles = TW'(n);
    @(negedge clk);
    go = 1'b0;
    forever begin
      bit any_before;
      go = 1'b0;
      if (adv) begin
        p++;
        if (p == n + 1) begin
          chk(busy == 1'b0, "R10 busy after drain", int'(busy), 0);
          chk(!(cmp_start || st_start || ld_start), "R10 no start after drain",
              int'({cmp_start, st_start, ld_start}), 0);
          break;
        end
        chk(busy == 1'b1, "R2 busy during run", int'(busy), 1);
        chk(cmp_start == exp_cmp(p, n), (p == n) ? "R6 drain compute" : "R4 compute start",
            int'(cmp_start), int'(exp_cmp(p, n)));
        chk(st_start == exp_st(p), (p == 0) ? "R4 first store" : "R6 store start",
            int'(st_start), int'(exp_st(p)));
        chk(ld_start == exp_ld(p, n), (p < 0) ? "R2 prologue load" : "R5 load overlap",
            int'(ld_start), int'(exp_ld(p, n)));
        if (p >= 0) begin
          chk(cmp_buf == p[0], "R3 compute buffer", int'(cmp_buf), int'(p[0]));
          chk(st_buf == !p[0], "R3 store buffer", int'(st_buf), int'(!p[0]));
          chk(int'(phase) == p, "R3 phase index", int'(phase), p);
        end else begin
          chk(phase == '0, "R2 prologue phase", int'(phase), 0);
        end
      end else begin
        chk(!(cmp_start || st_start || ld_start), "R7 R8 no early start",
            int'({cmp_start, st_start, ld_start}), 0);
      end
      adv = 1'b0;
      if (cmp_start) begin act[0] = 1'b1; rem[0] = $urandom_range(maxlat, 0); end
      if (st_start)  begin act[1] = 1'b1; rem[1] = $urandom_range(maxlat, 0); end
      if (ld_start)  begin act[2] = 1'b1; rem[2] = $urandom_range(maxlat, 0); end
      if (noise && ($urandom_range(15, 0) == 0)) begin
        go = 1'b1;
        num_tiles = TW'($urandom_range(9, 0));
      end
      any_before = act[0] || act[1] || act[2];
      for (int i = 0; i < 3; i++) begin
        if (act[i] && rem[i] == 0) begin
          d[i] = 1'b1;
          act[i] = 1'b0;
        end else if (act[i]) begin
          rem[i]--;
          d[i] = 1'b0;
        end else begin
          d[i] = noise && ($urandom_range(7, 0) == 0);
        end
      end
      cmp_done = d[0];
      st_done  = d[1];
      ld_done  = d[2];
      adv = any_before && !(act[0] || act[1] || act[2]);
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "R7 run stalled", cyc, 0);
        break;
      end
      @(negedge clk);
      cmp_done = 1'b0;
      st_done  = 1'b0;
      ld_done  = 1'b0;
    end
    go = 1'b0;
    cmp_done = 1'b0;
    st_done  = 1'b0;
    ld_done  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(!(cmp_start || st_start || ld_start), "R1 reset starts",
        int'({cmp_start, st_start, ld_start}), 0);
    rst_n = 1'b1;

    // R9: zero tile count is ignored
    @(negedge clk);
    go = 1'b1;
    num_tiles = '0;
    @(negedge clk);
    go = 1'b0;
    chk(busy == 1'b0, "R9 zero count busy", int'(busy), 0);
    chk(!(cmp_start || st_start || ld_start), "R9 zero count starts",
        int'({cmp_start, st_start, ld_start}), 0);

    run_tiles(1, 0, 1'b0);
    run_tiles(2, 3, 1'b0);
    run_tiles(3, 0, 1'b1);
    run_tiles(255, 2, 1'b1);
    for (int k = 0; k < 40; k++) begin
      run_tiles($urandom_range(7, 1), $urandom_range(6, 0), k[0]);
    end

    @(negedge clk);
    chk(busy == 1'b0, "R10 idle at end", int'(busy), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule